// File: doc/BRIEF.md
# RDMA Packet Opcode Sequencer

This block chooses the transport opcode for the next packet that a requester emits for a message. Its inputs are:

- the kind of work request,
- the kind of connection the queue uses,
- how many payload bytes of the message remain,
- the path MTU.

From these, together with the opcode of the last packet it accepted, it decides between a first, middle, last or only packet. It also maps single-packet operations such as reads and atomics to their one request opcode. When a combination of request kind and connection kind is not supported, it raises an error indication and gives no opcode.

The decision logic is combinational. The only state is a register that holds the previous opcode. That register loads when the downstream stage takes a packet through a valid/ready handshake. It is cleared to an "empty" marker by reset, or by a restart pulse that a retry flow raises, so that the next packet opens a new message. Besides the opcode, the block gives class flags (start, end, immediate, read, atomic) for use by later header-building stages.

Opcode = base + low code. The base is 0x00 on a reliable connection, 0x20 on an unreliable connection and 0x60 on a datagram queue. The empty marker and the error opcode are both 0xFF.

Request kinds: 0 send, 1 send-with-immediate, 2 send-with-invalidate, 3 write, 4 write-with-immediate, 5 read, 6 compare-swap, 7 fetch-add. Connection kinds: 0 reliable, 1 unreliable, 2 datagram, 3 reserved.

Top module: `rdma_opcode_seq`

## Requirements
- R1: The remainder fits when remain_len <= mtu_len. This includes remain_len == mtu_len, which produces a single ONLY packet (write ONLY low code 0x0A). At remain_len == mtu_len + 1 the remainder does not fit.
- R2: For a send or write request whose previous accepted opcode is the FIRST or MIDDLE of the same class on the same base, the output is LAST if the remainder fits and MIDDLE otherwise. The low codes are send FIRST 0x00, MIDDLE 0x01, LAST 0x02; write FIRST 0x06, MIDDLE 0x07, LAST 0x08.
- R3: In every other send or write case (empty marker, or a different class last), the output is ONLY if the remainder fits and FIRST otherwise. Send ONLY is low code 0x04 and write ONLY is 0x0A.
- R4: The immediate and invalidate variants change only the closing packet. Send-imm LAST/ONLY are 0x03/0x05, write-imm LAST/ONLY are 0x09/0x0B, and send-invalidate LAST/ONLY are 0x16/0x17. Their FIRST and MIDDLE packets use the plain codes.
- R5: On a reliable connection, a read gives 0x0C, compare-swap gives 0x13 and fetch-add gives 0x14, whatever the remainder.
- R6: On an unreliable connection, read, compare-swap, fetch-add and send-with-invalidate give an error.
- R7: On a datagram queue, send gives 0x64 and send-with-immediate gives 0x65 at any length. Every other request kind gives an error.
- R8: On an error, opcode is 0xFF and all class flags are 0. Connection kind 3 always gives an error.
- R9: Reset or restart sets the previous opcode to the empty marker. When restart and an accepted handshake fall in the same cycle, restart wins.
- R10: The previous-opcode register loads the output opcode only when pkt_valid, pkt_ready and no error all hold. At any other time it keeps its value.
- R11: is_start is set for FIRST, ONLY, read and atomic packets. is_end is set for LAST, ONLY, read and atomic packets. has_imm is set for the immediate variants, is_read for reads and is_atomic for atomics.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_kind | input | 3 | Work request kind |
| conn_kind | input | 2 | Connection kind of the queue |
| remain_len | input | LEN_W | Payload bytes still to send |
| mtu_len | input | LEN_W | Path MTU in bytes |
| pkt_valid | input | 1 | Requester presents a packet |
| pkt_ready | input | 1 | Downstream takes the packet |
| restart | input | 1 | Retry restart, clears previous opcode |
| opcode | output | 8 | Chosen opcode, 0xFF on error |
| op_err | output | 1 | Unsupported combination |
| is_start | output | 1 | Packet opens a message |
| is_end | output | 1 | Packet closes a message |
| has_imm | output | 1 | Immediate-carrying opcode |
| is_read | output | 1 | Read request opcode |
| is_atomic | output | 1 | Atomic request opcode |

## Verification
Two things can happen in the same cycle: a restart pulse and an accepted handshake. The first tries to clear the previous opcode and the second tries to load it. The bench opens an unreliable send with a FIRST packet. It then drives restart together with valid and ready while the MIDDLE opcode is on the output. The next packet of the same message must come out as FIRST again, which shows that the clear took priority over the load. A second hazard comes from error cycles that are handshaken: three such cycles are followed by a packet that must still continue the message opened before them.

// File: rtl/rdma_seq_pkg.sv
package rdma_seq_pkg;
  typedef enum logic [2:0] {
    RQ_SEND      = 3'd0,
    RQ_SEND_IMM  = 3'd1,
    RQ_SEND_INV  = 3'd2,
    RQ_WRITE     = 3'd3,
    RQ_WRITE_IMM = 3'd4,
    RQ_READ      = 3'd5,
    RQ_CSWAP     = 3'd6,
    RQ_FADD      = 3'd7
  } req_kind_e;

  typedef enum logic [1:0] {
    CN_RELIABLE   = 2'd0,
    CN_UNRELIABLE = 2'd1,
    CN_DGRAM      = 2'd2,
    CN_RSVD       = 2'd3
  } conn_kind_e;

  localparam logic [7:0] OP_NONE = 8'hFF;
  localparam logic [7:0] BASE_RC = 8'h00;
  localparam logic [7:0] BASE_UC = 8'h20;
  localparam logic [7:0] BASE_UD = 8'h60;

  localparam logic [4:0] L_SEND_FIRST    = 5'h00;
  localparam logic [4:0] L_SEND_MID      = 5'h01;
  localparam logic [4:0] L_SEND_LAST     = 5'h02;
  localparam logic [4:0] L_SEND_LAST_IMM = 5'h03;
  localparam logic [4:0] L_SEND_ONLY     = 5'h04;
  localparam logic [4:0] L_SEND_ONLY_IMM = 5'h05;
  localparam logic [4:0] L_WR_FIRST      = 5'h06;
  localparam logic [4:0] L_WR_MID        = 5'h07;
  localparam logic [4:0] L_WR_LAST       = 5'h08;
  localparam logic [4:0] L_WR_LAST_IMM   = 5'h09;
  localparam logic [4:0] L_WR_ONLY       = 5'h0A;
  localparam logic [4:0] L_WR_ONLY_IMM   = 5'h0B;
  localparam logic [4:0] L_READ_REQ      = 5'h0C;
  localparam logic [4:0] L_CSWAP         = 5'h13;
  localparam logic [4:0] L_FADD          = 5'h14;
  localparam logic [4:0] L_SEND_LAST_INV = 5'h16;
  localparam logic [4:0] L_SEND_ONLY_INV = 5'h17;
endpackage

// File: rtl/seq_fit_cmp.sv
module seq_fit_cmp #(
  parameter int LEN_W = 32
) (
  input  logic [LEN_W-1:0] remain_len,
  input  logic [LEN_W-1:0] mtu_len,
  output logic             fits
);
  // The rest of the message goes out in one packet when it is no larger than the MTU
  assign fits = (remain_len <= mtu_len);
endmodule

// File: rtl/seq_op_pick.sv
module seq_op_pick
  import rdma_seq_pkg::*;
(
  input  logic [2:0] req_kind,
  input  logic [1:0] conn_kind,
  input  logic       fits,
  input  logic [7:0] prev_op,
  output logic [7:0] opcode,
  output logic       op_err,
  output logic       is_start,
  output logic       is_end,
  output logic       has_imm,
  output logic       is_read,
  output logic       is_atomic
);
  req_kind_e  rk;
  conn_kind_e ck;
  logic [7:0] base;
  logic [4:0] low;
  logic       err;
  logic       send_cont;
  logic       wr_cont;
  logic [4:0] send_close;
  logic [4:0] wr_close;

  assign rk = req_kind_e'(req_kind);
  assign ck = conn_kind_e'(conn_kind);

  // A message continues only if the last packet was an opening or middle packet of the same class
  assign send_cont = (prev_op == (base | {3'b0, L_SEND_FIRST})) ||
                     (prev_op == (base | {3'b0, L_SEND_MID}));
  assign wr_cont   = (prev_op == (base | {3'b0, L_WR_FIRST})) ||
                     (prev_op == (base | {3'b0, L_WR_MID}));

  // Closing code per variant: chosen by whether the message continues
  always_comb begin
    case (rk)
      RQ_SEND_IMM: send_close = send_cont ? L_SEND_LAST_IMM : L_SEND_ONLY_IMM;
      RQ_SEND_INV: send_close = send_cont ? L_SEND_LAST_INV : L_SEND_ONLY_INV;
      default:     send_close = send_cont ? L_SEND_LAST     : L_SEND_ONLY;
    endcase
    if (rk == RQ_WRITE_IMM) wr_close = wr_cont ? L_WR_LAST_IMM : L_WR_ONLY_IMM;
    else                    wr_close = wr_cont ? L_WR_LAST     : L_WR_ONLY;
  end

  always_comb begin
    err  = 1'b0;
    low  = 5'h00;
    base = BASE_RC;
    case (ck)
      CN_RELIABLE, CN_UNRELIABLE: begin
        base = (ck == CN_UNRELIABLE) ? BASE_UC : BASE_RC;
        case (rk)
          RQ_SEND, RQ_SEND_IMM, RQ_SEND_INV: begin
            if (ck == CN_UNRELIABLE && rk == RQ_SEND_INV) err = 1'b1;
            else if (fits) low = send_close;
            else           low = send_cont ? L_SEND_MID : L_SEND_FIRST;
          end
          RQ_WRITE, RQ_WRITE_IMM: begin
            if (fits) low = wr_close;
            else      low = wr_cont ? L_WR_MID : L_WR_FIRST;
          end
          RQ_READ:  if (ck == CN_UNRELIABLE) err = 1'b1; else low = L_READ_REQ;
          RQ_CSWAP: if (ck == CN_UNRELIABLE) err = 1'b1; else low = L_CSWAP;
          default:  if (ck == CN_UNRELIABLE) err = 1'b1; else low = L_FADD;
        endcase
      end
      CN_DGRAM: begin
        base = BASE_UD;
        if (rk == RQ_SEND)          low = L_SEND_ONLY;
        else if (rk == RQ_SEND_IMM) low = L_SEND_ONLY_IMM;
        else                        err = 1'b1;
      end
      default: err = 1'b1;
    endcase
  end

  assign op_err = err;
  assign opcode = err ? OP_NONE : (base | {3'b0, low});

  // Class flags decoded from the low code, masked on error
  always_comb begin
    is_start  = 1'b0;
    is_end    = 1'b0;
    has_imm   = 1'b0;
    is_read   = 1'b0;
    is_atomic = 1'b0;
    if (!err) begin
      case (low)
        L_SEND_FIRST, L_WR_FIRST:                       is_start = 1'b1;
        L_SEND_LAST, L_SEND_LAST_INV, L_WR_LAST:        is_end   = 1'b1;
        L_SEND_LAST_IMM, L_WR_LAST_IMM: begin
          is_end  = 1'b1;
          has_imm = 1'b1;
        end
        L_SEND_ONLY, L_SEND_ONLY_INV, L_WR_ONLY: begin
          is_start = 1'b1;
          is_end   = 1'b1;
        end
        L_SEND_ONLY_IMM, L_WR_ONLY_IMM: begin
          is_start = 1'b1;
          is_end   = 1'b1;
          has_imm  = 1'b1;
        end
        L_READ_REQ: begin
          is_start = 1'b1;
          is_end   = 1'b1;
          is_read  = 1'b1;
        end
        L_CSWAP, L_FADD: begin
          is_start  = 1'b1;
          is_end    = 1'b1;
          is_atomic = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/seq_prev_reg.sv
module seq_prev_reg
  import rdma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       accept,
  input  logic [7:0] op_in,
  output logic [7:0] prev_q
);
  // Clearing outranks loading, so a retry always reopens the message
  always_ff @(posedge clk) begin
    if (rst || restart) prev_q <= OP_NONE;
    else if (accept)    prev_q <= op_in;
  end
endmodule

// File: rtl/rdma_opcode_seq.sv
module rdma_opcode_seq
  import rdma_seq_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       req_kind,
  input  logic [1:0]       conn_kind,
  input  logic [LEN_W-1:0] remain_len,
  input  logic [LEN_W-1:0] mtu_len,
  input  logic             pkt_valid,
  input  logic             pkt_ready,
  input  logic             restart,
  output logic [7:0]       opcode,
  output logic             op_err,
  output logic             is_start,
  output logic             is_end,
  output logic             has_imm,
  output logic             is_read,
  output logic             is_atomic
);
  logic       fits;
  logic       accept;
  logic [7:0] prev_q;

  seq_fit_cmp #(.LEN_W(LEN_W)) fit_i (
    .remain_len (remain_len),
    .mtu_len    (mtu_len),
    .fits       (fits)
  );

  seq_op_pick pick_i (
    .req_kind  (req_kind),
    .conn_kind (conn_kind),
    .fits      (fits),
    .prev_op   (prev_q),
    .opcode    (opcode),
    .op_err    (op_err),
    .is_start  (is_start),
    .is_end    (is_end),
    .has_imm   (has_imm),
    .is_read   (is_read),
    .is_atomic (is_atomic)
  );

  assign accept = pkt_valid & pkt_ready & ~op_err;

  seq_prev_reg prev_i (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .accept  (accept),
    .op_in   (opcode),
    .prev_q  (prev_q)
  );
endmodule

// File: rtl/rdma_opcode_seq_chk.sv
module rdma_opcode_seq_chk #(
  parameter int LEN_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       req_kind,
  input logic [1:0]       conn_kind,
  input logic [LEN_W-1:0] remain_len,
  input logic [LEN_W-1:0] mtu_len,
  input logic             pkt_valid,
  input logic             pkt_ready,
  input logic             restart,
  input logic [7:0]       opcode,
  input logic             op_err,
  input logic             is_start,
  input logic             is_end,
  input logic [7:0]       prev_q
);
  p_fit_end_r1: assert property (@(posedge clk) disable iff (rst)
    (!op_err && remain_len <= mtu_len) |-> is_end);

  p_split_open_r2: assert property (@(posedge clk) disable iff (rst)
    (!op_err && remain_len > mtu_len && conn_kind != 2'd2 && req_kind <= 3'd4) |-> !is_end);

  p_uc_reject_r6: assert property (@(posedge clk) disable iff (rst)
    (conn_kind == 2'd1 && (req_kind >= 3'd5 || req_kind == 3'd2)) |-> op_err);

  p_dg_single_r7: assert property (@(posedge clk) disable iff (rst)
    (conn_kind == 2'd2 && !op_err) |-> (is_start && is_end));

  p_err_blank_r8: assert property (@(posedge clk) disable iff (rst)
    op_err |-> (opcode == 8'hFF && !is_start && !is_end));

  p_restart_open_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(restart) && !op_err) |-> is_start);

  p_prev_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(restart) && !$past(pkt_valid && pkt_ready && !op_err)) |-> $stable(prev_q));
endmodule

bind rdma_opcode_seq rdma_opcode_seq_chk #(.LEN_W(LEN_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_kind   (req_kind),
  .conn_kind  (conn_kind),
  .remain_len (remain_len),
  .mtu_len    (mtu_len),
  .pkt_valid  (pkt_valid),
  .pkt_ready  (pkt_ready),
  .restart    (restart),
  .opcode     (opcode),
  .op_err     (op_err),
  .is_start   (is_start),
  .is_end     (is_end),
  .prev_q     (prev_q)
);

// File: tb/rdma_opcode_seq_tb_top.sv
module rdma_opcode_seq_tb_top;
  localparam int LEN_W = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       req_kind = 3'd0;
  logic [1:0]       conn_kind = 2'd0;
  logic [LEN_W-1:0] remain_len = '0;
  logic [LEN_W-1:0] mtu_len = 32'd1024;
  logic             pkt_valid = 1'b0;
  logic             pkt_ready = 1'b0;
  logic             restart = 1'b0;
  logic [7:0]       opcode;
  logic             op_err, is_start, is_end, has_imm, is_read, is_atomic;

  int checks = 0;
  int bad = 0;
  int mprev = 255;
  bit done = 0;

  always #5 clk = ~clk;

  rdma_opcode_seq #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst(rst), .req_kind(req_kind), .conn_kind(conn_kind),
    .remain_len(remain_len), .mtu_len(mtu_len), .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready), .restart(restart), .opcode(opcode), .op_err(op_err),
    .is_start(is_start), .is_end(is_end), .has_imm(has_imm),
    .is_read(is_read), .is_atomic(is_atomic)
  );

  // Reference: -1 means error
  function automatic int ref_op(int rq, int cn, int rem, int mtu, int prev);
    bit one = (rem <= mtu);
    int b;
    bit in_send, in_wr;
    if (cn == 3) return -1;
    if (cn == 2) begin
      if (rq == 0) return 'h64;
      if (rq == 1) return 'h65;
      return -1;
    end
    b = (cn == 1) ? 'h20 : 'h00;
    in_send = (prev == b + 'h00) || (prev == b + 'h01);
    in_wr   = (prev == b + 'h06) || (prev == b + 'h07);
    if (cn == 1 && (rq == 2 || rq >= 5)) return -1;
    if (rq == 5) return 'h0C;
    if (rq == 6) return 'h13;
    if (rq == 7) return 'h14;
    if (rq <= 2) begin
      if (!one) return b + (in_send ? 'h01 : 'h00);
      if (rq == 0) return b + (in_send ? 'h02 : 'h04);
      if (rq == 1) return b + (in_send ? 'h03 : 'h05);
      return b + (in_send ? 'h16 : 'h17);
    end
    if (!one) return b + (in_wr ? 'h07 : 'h06);
    if (rq == 3) return b + (in_wr ? 'h08 : 'h0A);
    return b + (in_wr ? 'h09 : 'h0B);
  endfunction

  // Expected flag vector {start,end,imm,read,atomic}
  function automatic logic [4:0] ref_flags(int op);
    int l;
    if (op < 0) return 5'b00000;
    l = op % 32;
    case (l)
      'h00, 'h06:               return 5'b10000;
      'h01, 'h07:               return 5'b00000;
      'h02, 'h08, 'h16:         return 5'b01000;
      'h03, 'h09:               return 5'b01100;
      'h04, 'h0A, 'h17:         return 5'b11000;
      'h05, 'h0B:               return 5'b11100;
      'h0C:                     return 5'b11010;
      default:                  return 5'b11001;
    endcase
  endfunction

  task automatic compare(string tag, int eop);
    logic [7:0] e8 = (eop < 0) ? 8'hFF : eop[7:0];
    logic [4:0] ef = ref_flags(eop);
    logic [4:0] af = {is_start, is_end, has_imm, is_read, is_atomic};
    checks++;
    if (opcode !== e8 || op_err !== (eop < 0) || af !== ef) begin
      bad++;
      $display("FAIL %s: opcode=%h err=%b flags=%b expected opcode=%h err=%b flags=%b",
               tag, opcode, op_err, af, e8, (eop < 0), ef);
    end
  endtask

  task automatic step(string tag, int rq, int cn, int rem, int mtu, bit v, bit r, bit rs);
    int eop;
    @(posedge clk); #1;
    req_kind = rq[2:0]; conn_kind = cn[1:0];
    remain_len = rem; mtu_len = mtu;
    pkt_valid = v; pkt_ready = r; restart = rs;
    @(negedge clk);
    eop = ref_op(rq, cn, rem, mtu, mprev);
    compare(tag, eop);
    if (rs) mprev = 255;
    else if (v && r && eop >= 0) mprev = eop;
  endtask

  initial begin
    // Reset state with a handshake offered: empty marker gives ONLY
    req_kind = 3'd3; conn_kind = 2'd0; remain_len = 32'd100; mtu_len = 32'd1024;
    pkt_valid = 1'b1; pkt_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R9 reset", 'h0A);
    @(posedge clk); #1 rst = 1'b0;
    mprev = 255;
    step("R9 post-reset", 3, 0, 100, 1024, 0, 0, 0);
    step("R3 rc send first", 0, 0, 3000, 1024, 1, 1, 0);
    step("R2 rc send middle", 0, 0, 1976, 1024, 1, 1, 0);
    step("R4 rc send-imm last", 1, 0, 952, 1024, 1, 1, 0);
    step("R1 write exact mtu", 3, 0, 1024, 1024, 1, 1, 0);
    step("R1 write mtu+1", 4, 0, 1025, 1024, 1, 1, 0);
    step("R10 no ready", 4, 0, 1, 1024, 1, 0, 0);
    step("R10 then ready", 4, 0, 1, 1024, 1, 1, 0);
    step("R4 send-inv only", 2, 0, 10, 1024, 1, 1, 0);
    step("R4 send-inv first", 2, 0, 2000, 1024, 1, 1, 0);
    step("R4 send-inv last", 2, 0, 976, 1024, 1, 1, 0);
    step("R5 read", 5, 0, 5000, 1024, 1, 1, 0);
    step("R5 cswap", 6, 0, 8, 1024, 1, 1, 0);
    step("R5 fadd", 7, 0, 8, 1024, 1, 1, 0);
    step("R3 uc send first", 0, 1, 3000, 1024, 1, 1, 0);
    step("R9 restart with accept", 0, 1, 1976, 1024, 1, 1, 1);
    step("R9 reopened", 0, 1, 1976, 1024, 1, 1, 0);
    step("R6 uc read", 5, 1, 10, 1024, 1, 1, 0);
    step("R6 uc cswap", 6, 1, 10, 1024, 1, 1, 0);
    step("R6 uc send-inv", 2, 1, 10, 1024, 1, 1, 0);
    step("R10 err no load", 0, 1, 1000, 1024, 1, 1, 0);
    step("R7 ud long send", 0, 2, 9000, 1024, 1, 1, 0);
    step("R7 ud send-imm", 1, 2, 9000, 1024, 1, 1, 0);
    step("R7 ud write", 3, 2, 10, 1024, 1, 1, 0);
    step("R8 rsvd conn", 0, 3, 10, 1024, 1, 1, 0);
    step("R11 write first", 3, 0, 2048, 1024, 1, 1, 0);
    step("R11 write last", 3, 0, 1024, 1024, 1, 1, 0);
    step("R3 write open", 3, 0, 3000, 1024, 1, 1, 0);
    step("R3 other class", 0, 0, 10, 1024, 1, 1, 0);
    step("R9 restart alone", 3, 0, 3000, 1024, 0, 0, 1);
    step("R3 after restart", 3, 0, 3000, 512, 1, 1, 0);
    step("R2 small mtu middle", 3, 0, 2488, 512, 1, 1, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule